// File: doc/BRIEF.md
# Floppy Controller Command/Result Sequencer

This block is the host-facing handshake of a floppy disk controller. A host on a small register bus writes command bytes into a byte-wide data port and polls a status byte. That status byte shows whether the sequencer wants a byte, has a byte ready, or is busy. The sequencer collects the number of bytes that the first byte (the opcode) calls for. It then runs the command against an ideal cylinder register and queues the result bytes, which the host reads back one at a time. An interrupt line marks command completion and is withdrawn at a fixed point of the result read-out.

Absolute seek, relative seek in either direction, sense-interrupt status and read-ID are modelled in full. Read-ID waits a programmable number of cycles in place of waiting for a sector header. Read and verify commands are accepted with their full parameter list. Because the block has no data path, they finish at once with an abnormal-termination status and the sector address echoed back.

Top module: `fdc_cmd_sequencer`

## Requirements
- R1: After reset the status byte reads 0x80, the data port reads 0x00 and `irq` is low.
- R2: Status bit 7 means "ready for transfer", bit 6 means "direction is device to host", bit 5 is always 0 and bit 4 means "busy". Reading offset 4 gives the status byte, offset 5 is the data port, and every other offset reads 0x00. The status reads 0x80 when idle, 0x90 once part of a command has been taken, 0x10 while a command executes and 0xD0 while results are pending.
- R3: A data-port write is taken only while bit 7 is set and bit 6 is clear. Writes at other times, writes to other offsets, and data-port reads outside the result phase change nothing.
- R4: Opcode 0x0F takes two more bytes: a select byte (bit 2 is the head, bits 1:0 the drive) and a target cylinder. The cylinder becomes min(target, CYL_MAX). No result bytes follow, `irq` rises on the edge that takes the third byte, and a seek interrupt becomes pending.
- R5: Opcode 0xCF (step in) adds its count byte to the cylinder, saturating at CYL_MAX. Opcode 0x8F (step out) subtracts the count, stopping at 0. Both take 3 bytes in total and complete like R4.
- R6: Opcode 0x08 issued while a seek interrupt is pending returns two bytes: 0x20 OR the select byte's bits 2:0, then the cylinder. The pending state is cleared.
- R7: Opcode 0x08 issued with nothing pending returns the single byte 0x80.
- R8: A first byte that, ANDed with 0xBF, gives 0x0A (read-ID) takes 2 bytes. The block then stays busy for exactly READID_DELAY cycles with `irq` low. It then raises `irq` and returns 7 bytes: select[2:0], 0x00, 0x00, cylinder, select[2], 0x01, 0x02.
- R9: A first byte whose bits 4:0 are 0x06 (read) or 0x16 (verify) takes 9 bytes in total. The result phase starts at once with `irq` raised and returns 0x40 OR select[2:0], 0x00, 0x00, then command bytes 3, 4, 5 and 6 (cylinder, head, sector, size code) in that order.
- R10: `irq` never rises while command bytes are still being collected. Once raised, it stays high until the last result byte of an interrupting command is read, and drops on that read.
- R11: Any other opcode returns the single byte 0x80 and leaves `irq` unchanged.
- R12: Reading the last result byte returns the block to the idle status 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe; a data-port read pops a result byte |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from offset and state) |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with CYL_MAX = 15, so a single step-in byte of 20 drives the cylinder into saturation. An absolute seek to 200 and a step-out of 40 hit the upper and lower limits. READID_DELAY = 6 keeps the busy window short enough to count each cycle of it and to confirm that `irq` stays low through it. A behavioural model holds the pending results in a queue and checks the bus read data and `irq` against the design on every clock. This covers the edges where `irq` rises and falls relative to the strobes.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_EXEC = 2'd1,
        PH_RES  = 2'd2
    } phase_e;

    typedef enum logic [2:0] {
        K_SEEK,
        K_STEP_IN,
        K_STEP_OUT,
        K_SENSE,
        K_READ_ID,
        K_XFER,
        K_BAD
    } cmd_kind_e;

    localparam int CMD_BYTES = 9;
    localparam int RES_BYTES = 7;
    localparam int LEN_W     = $clog2(CMD_BYTES + 1);
    localparam int RIDX_W    = $clog2(RES_BYTES + 1);

    localparam logic [2:0] OFS_STATUS = 3'd4;
    localparam logic [2:0] OFS_DATA   = 3'd5;

    localparam logic [7:0] ST_INVALID   = 8'h80;
    localparam logic [7:0] ST0_SEEK_END = 8'h20;
    localparam logic [7:0] ST0_ABNORMAL = 8'h40;

endpackage

// File: rtl/fdc_op_decode.sv
module fdc_op_decode
    import fdc_seq_pkg::*;
(
    input  logic [7:0]       opcode,
    output cmd_kind_e        kind,
    output logic [LEN_W-1:0] total_len
);

    always_comb begin
        kind      = K_BAD;
        total_len = LEN_W'(1);
        if (opcode == 8'h0F) begin
            kind      = K_SEEK;
            total_len = LEN_W'(3);
        end else if (opcode == 8'hCF) begin
            kind      = K_STEP_IN;
            total_len = LEN_W'(3);
        end else if (opcode == 8'h8F) begin
            kind      = K_STEP_OUT;
            total_len = LEN_W'(3);
        end else if (opcode == 8'h08) begin
            kind      = K_SENSE;
            total_len = LEN_W'(1);
        end else if ((opcode & 8'hBF) == 8'h0A) begin
            kind      = K_READ_ID;
            total_len = LEN_W'(2);
        end else if (opcode[4:0] == 5'h06 || opcode[4:0] == 5'h16) begin
            kind      = K_XFER;
            total_len = LEN_W'(CMD_BYTES);
        end
    end

endmodule

// File: rtl/fdc_cyl_track.sv
module fdc_cyl_track
    import fdc_seq_pkg::*;
#(
    parameter int CYL_MAX = 79
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      upd,
    input  cmd_kind_e kind,
    input  logic [7:0] amount,
    output logic [7:0] cyl
);

    localparam logic [8:0] LIMIT = 9'(CYL_MAX);

    typedef struct packed {
        logic [7:0] cyl;
    } trk_t;

    trk_t s_q, s_d;
    logic [8:0] sum;

    always_comb begin
        s_d = s_q;
        sum = {1'b0, s_q.cyl} + {1'b0, amount};
        if (upd) begin
            case (kind)
                K_SEEK:     s_d.cyl = ({1'b0, amount} > LIMIT) ? LIMIT[7:0] : amount;
                K_STEP_IN:  s_d.cyl = (sum > LIMIT) ? LIMIT[7:0] : sum[7:0];
                K_STEP_OUT: s_d.cyl = (amount > s_q.cyl) ? 8'd0 : s_q.cyl - amount;
                default:    s_d.cyl = s_q.cyl;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cyl = s_q.cyl;

    assert_cyl_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, s_q.cyl} <= LIMIT);

    assert_cyl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(s_q.cyl));

endmodule

// File: rtl/fdc_exec_timer.sv
module fdc_exec_timer #(
    parameter int DELAY = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);

    localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;
    localparam logic [CW-1:0] LOAD = CW'(DELAY - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t s_q, s_d;

    assign done = s_q.busy && (s_q.cnt == '0);

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = LOAD;
        end else if (done) begin
            s_d.busy = 1'b0;
        end else if (s_q.busy) begin
            s_d.cnt = s_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_timer_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/fdc_cmd_sequencer.sv
module fdc_cmd_sequencer
    import fdc_seq_pkg::*;
#(
    parameter int CYL_MAX      = 79,
    parameter int READID_DELAY = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_addr,
    input  logic       bus_rd,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq
);

    typedef struct packed {
        phase_e                          phase;
        logic [LEN_W-1:0]                cnt;
        logic [CMD_BYTES-1:0][7:0]       cmd;
        logic [RES_BYTES-1:0][7:0]       res;
        logic [RIDX_W-1:0]               rlen;
        logic [RIDX_W-1:0]               idx;
        logic                            res_irq;
        logic                            res_clr;
        logic                            irq;
        logic                            pend;
        logic [7:0]                      pend_st0;
    } seq_t;

    seq_t s_q, s_d;

    logic [CMD_BYTES-1:0][7:0] cmd_nx;
    logic [7:0]       dec_in;
    cmd_kind_e        dec_kind;
    logic [LEN_W-1:0] dec_len;
    logic             wr_data, rd_data;
    logic             cyl_upd, tmr_start, tmr_done, fin_evt;
    logic [7:0]       cyl;
    logic [7:0]       status;

    assign wr_data = bus_wr && (bus_addr == OFS_DATA);
    assign rd_data = bus_rd && (bus_addr == OFS_DATA);
    assign dec_in  = (s_q.cnt == '0) ? bus_wdata : s_q.cmd[0];

    fdc_op_decode u_dec (
        .opcode    (dec_in),
        .kind      (dec_kind),
        .total_len (dec_len)
    );

    fdc_cyl_track #(.CYL_MAX(CYL_MAX)) u_trk (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (cyl_upd),
        .kind   (dec_kind),
        .amount (cmd_nx[2]),
        .cyl    (cyl)
    );

    fdc_exec_timer #(.DELAY(READID_DELAY)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .done  (tmr_done)
    );

    always_comb begin
        status    = 8'h00;
        status[7] = (s_q.phase != PH_EXEC);
        status[6] = (s_q.phase == PH_RES);
        status[4] = (s_q.phase != PH_CMD) || (s_q.cnt != '0);
    end

    always_comb begin
        s_d       = s_q;
        cmd_nx    = s_q.cmd;
        cyl_upd   = 1'b0;
        tmr_start = 1'b0;
        fin_evt   = 1'b0;
        cmd_nx[s_q.cnt] = bus_wdata;
        case (s_q.phase)
            PH_CMD: begin
                if (wr_data) begin
                    s_d.cmd = cmd_nx;
                    if ((s_q.cnt + LEN_W'(1)) != dec_len) begin
                        s_d.cnt = s_q.cnt + LEN_W'(1);
                    end else begin
                        s_d.cnt = '0;
                        s_d.idx = '0;
                        s_d.res = '0;
                        case (dec_kind)
                            K_SEEK, K_STEP_IN, K_STEP_OUT: begin
                                cyl_upd      = 1'b1;
                                fin_evt      = 1'b1;
                                s_d.irq      = 1'b1;
                                s_d.pend     = 1'b1;
                                s_d.pend_st0 = ST0_SEEK_END | {5'b0, cmd_nx[1][2:0]};
                            end
                            K_SENSE: begin
                                s_d.phase = PH_RES;
                                if (s_q.pend) begin
                                    s_d.res[0]  = s_q.pend_st0;
                                    s_d.res[1]  = cyl;
                                    s_d.rlen    = RIDX_W'(2);
                                    s_d.res_irq = 1'b1;
                                    s_d.res_clr = 1'b1;
                                end else begin
                                    s_d.res[0]  = ST_INVALID;
                                    s_d.rlen    = RIDX_W'(1);
                                    s_d.res_irq = 1'b0;
                                    s_d.res_clr = 1'b0;
                                end
                            end
                            K_READ_ID: begin
                                s_d.phase = PH_EXEC;
                                tmr_start = 1'b1;
                            end
                            K_XFER: begin
                                fin_evt     = 1'b1;
                                s_d.phase   = PH_RES;
                                s_d.irq     = 1'b1;
                                s_d.res_irq = 1'b1;
                                s_d.res_clr = 1'b0;
                                s_d.rlen    = RIDX_W'(RES_BYTES);
                                s_d.res[0]  = ST0_ABNORMAL | {5'b0, cmd_nx[1][2:0]};
                                s_d.res[3]  = cmd_nx[2];
                                s_d.res[4]  = cmd_nx[3];
                                s_d.res[5]  = cmd_nx[4];
                                s_d.res[6]  = cmd_nx[5];
                            end
                            default: begin
                                s_d.phase   = PH_RES;
                                s_d.res[0]  = ST_INVALID;
                                s_d.rlen    = RIDX_W'(1);
                                s_d.res_irq = 1'b0;
                                s_d.res_clr = 1'b0;
                            end
                        endcase
                    end
                end
            end
            PH_EXEC: begin
                if (tmr_done) begin
                    fin_evt     = 1'b1;
                    s_d.phase   = PH_RES;
                    s_d.irq     = 1'b1;
                    s_d.res_irq = 1'b1;
                    s_d.res_clr = 1'b0;
                    s_d.rlen    = RIDX_W'(RES_BYTES);
                    s_d.idx     = '0;
                    s_d.res     = '0;
                    s_d.res[0]  = {5'b0, s_q.cmd[1][2:0]};
                    s_d.res[3]  = cyl;
                    s_d.res[4]  = {7'b0, s_q.cmd[1][2]};
                    s_d.res[5]  = 8'h01;
                    s_d.res[6]  = 8'h02;
                end
            end
            default: begin
                if (rd_data) begin
                    if (s_q.idx == s_q.rlen - RIDX_W'(1)) begin
                        s_d.phase = PH_CMD;
                        s_d.idx   = '0;
                        if (s_q.res_irq) s_d.irq  = 1'b0;
                        if (s_q.res_clr) s_d.pend = 1'b0;
                    end else begin
                        s_d.idx = s_q.idx + RIDX_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_addr == OFS_STATUS)
            bus_rdata = status;
        else if (bus_addr == OFS_DATA && s_q.phase == PH_RES)
            bus_rdata = s_q.res[s_q.idx];
    end

    assign irq = s_q.irq;

    assert_irq_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.irq) |-> $past(fin_evt));

    assert_irq_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.irq) |-> $past(rd_data && s_q.phase == PH_RES));

    assert_idx_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_RES) |-> (s_q.idx < s_q.rlen));

    assert_exec_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_done |=> (s_q.phase == PH_RES));

    assert_wr_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_RES && wr_data && !rd_data) |=>
            (s_q.phase == PH_RES && $stable(s_q.idx) && $stable(s_q.res)));

endmodule

// File: tb/fdc_cmd_sequencer_bench.sv
module fdc_cmd_sequencer_bench;

    localparam int CYL_MAX = 15;
    localparam int DELAY   = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = 3'd0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    fdc_cmd_sequencer #(.CYL_MAX(CYL_MAX), .READID_DELAY(DELAY)) u_fdc_cmd_sequencer (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_rd(rd), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
    );

    // behavioural reference model
    int  m_phase;
    int  m_cmd[$];
    int  m_res[$];
    bit  m_irq, m_pend, m_resirq, m_clr;
    int  m_cyl, m_st0, m_left, m_sel;

    function automatic int need_of(int op);
        if (op == 'h0F || op == 'hCF || op == 'h8F) return 3;
        if (op == 'h08) return 1;
        if ((op & 'hBF) == 'h0A) return 2;
        if ((op & 'h1F) == 'h06 || (op & 'h1F) == 'h16) return 9;
        return 1;
    endfunction

    function automatic int m_status();
        if (m_phase == 1) return 'h10;
        if (m_phase == 2) return 'hD0;
        return (m_cmd.size() > 0) ? 'h90 : 'h80;
    endfunction

    task automatic m_complete();
        int op = m_cmd[0];
        int sel = (m_cmd.size() > 1) ? m_cmd[1] : 0;
        int amt = (m_cmd.size() > 2) ? m_cmd[2] : 0;
        m_res.delete();
        if (op == 'h0F || op == 'hCF || op == 'h8F) begin
            if (op == 'h0F) m_cyl = (amt > CYL_MAX) ? CYL_MAX : amt;
            else if (op == 'hCF) m_cyl = (m_cyl + amt > CYL_MAX) ? CYL_MAX : m_cyl + amt;
            else m_cyl = (amt > m_cyl) ? 0 : m_cyl - amt;
            m_irq = 1; m_pend = 1; m_st0 = 'h20 | (sel & 7);
        end else if (op == 'h08) begin
            m_phase = 2;
            if (m_pend) begin
                m_res.push_back(m_st0); m_res.push_back(m_cyl);
                m_resirq = 1; m_clr = 1;
            end else begin
                m_res.push_back('h80); m_resirq = 0; m_clr = 0;
            end
        end else if ((op & 'hBF) == 'h0A) begin
            m_phase = 1; m_left = DELAY; m_sel = sel;
        end else if ((op & 'h1F) == 'h06 || (op & 'h1F) == 'h16) begin
            m_phase = 2; m_irq = 1; m_resirq = 1; m_clr = 0;
            m_res.push_back('h40 | (sel & 7)); m_res.push_back(0); m_res.push_back(0);
            for (int i = 2; i <= 5; i++) m_res.push_back(m_cmd[i]);
        end else begin
            m_phase = 2; m_res.push_back('h80); m_resirq = 0; m_clr = 0;
        end
        m_cmd.delete();
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_cmd.delete(); m_res.delete();
            m_irq = 0; m_pend = 0; m_resirq = 0; m_clr = 0; m_cyl = 0; m_st0 = 0;
        end else if (m_phase == 1) begin
            m_left--;
            if (m_left == 0) begin
                m_res.delete();
                m_res.push_back(m_sel & 7); m_res.push_back(0); m_res.push_back(0);
                m_res.push_back(m_cyl); m_res.push_back((m_sel >> 2) & 1);
                m_res.push_back(1); m_res.push_back(2);
                m_phase = 2; m_irq = 1; m_resirq = 1; m_clr = 0;
            end
        end else if (m_phase == 0 && wr && addr == 3'd5) begin
            m_cmd.push_back(int'(wdata));
            if (m_cmd.size() == need_of(m_cmd[0])) m_complete();
        end else if (m_phase == 2 && rd && addr == 3'd5) begin
            void'(m_res.pop_front());
            if (m_res.size() == 0) begin
                m_phase = 0;
                if (m_resirq) m_irq = 0;
                if (m_clr) m_pend = 0;
            end
        end
    end

    task automatic check(int act, int exp, string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always begin
        @(negedge clk);
        #5;
        if (rst_n && !finished) begin
            int exp;
            check(int'(irq), int'(m_irq), "R10 irq vs model");
            if (addr == 3'd4) exp = m_status();
            else if (addr == 3'd5 && m_phase == 2) exp = m_res[0];
            else exp = 0;
            check(int'(rdata), exp, "R2 read data vs model");
        end
    end

    task automatic bus_write(logic [2:0] a, logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic expect_reg(logic [2:0] a, int exp, string tag);
        @(negedge clk); addr = a; #1;
        check(int'(rdata), exp, tag);
    endtask

    task automatic pop_data(int exp, string tag);
        @(negedge clk); addr = 3'd5; #1;
        check(int'(rdata), exp, tag);
        rd = 1'b1;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic seek_cmd(logic [7:0] op, logic [7:0] sel, logic [7:0] amt);
        bus_write(3'd5, op);
        bus_write(3'd5, sel);
        #1 check(int'(irq), 0, "R10 no irq while collecting");
        bus_write(3'd5, amt);
        #1 check(int'(irq), 1, "R4 irq after seek");
    endtask

    task automatic sense_expect(int st0, int cyl, string tag);
        bus_write(3'd5, 8'h08);
        pop_data(st0, {tag, " st0"});
        #1 check(int'(irq), 1, "R10 irq held before last byte");
        pop_data(cyl, {tag, " cylinder"});
        #1 check(int'(irq), 0, "R10 irq dropped after last byte");
        expect_reg(3'd4, 'h80, "R12 idle after results");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_reg(3'd4, 'h80, "R1 reset status");
        expect_reg(3'd5, 'h00, "R1 reset data port");
        #1 check(int'(irq), 0, "R1 reset irq");

        bus_write(3'd2, 8'h55);
        expect_reg(3'd4, 'h80, "R3 other offset write ignored");
        pop_data('h00, "R3 data read in command phase");
        expect_reg(3'd4, 'h80, "R3 status unchanged by idle read");

        bus_write(3'd5, 8'h0F);
        expect_reg(3'd4, 'h90, "R2 busy while collecting");
        bus_write(3'd5, 8'h00);
        #1 check(int'(irq), 0, "R10 no irq while collecting");
        bus_write(3'd5, 8'h05);
        #1 check(int'(irq), 1, "R4 irq after seek");
        expect_reg(3'd4, 'h80, "R4 no result phase after seek");
        bus_write(3'd5, 8'h08);
        expect_reg(3'd4, 'hD0, "R6 result status");
        pop_data('h20, "R6 sense st0");
        #1 check(int'(irq), 1, "R10 irq held before last byte");
        pop_data(5, "R6 sense cylinder");
        #1 check(int'(irq), 0, "R10 irq dropped");
        expect_reg(3'd4, 'h80, "R12 idle after results");

        bus_write(3'd5, 8'h08);
        pop_data('h80, "R7 sense without pending");
        expect_reg(3'd4, 'h80, "R7 single byte only");

        seek_cmd(8'hCF, 8'h00, 8'd20);
        sense_expect('h20, 15, "R5 step in saturates");
        seek_cmd(8'h8F, 8'h00, 8'd3);
        sense_expect('h20, 12, "R5 step out");
        seek_cmd(8'h8F, 8'h00, 8'd40);
        sense_expect('h20, 0, "R5 step out floor");
        seek_cmd(8'h0F, 8'h00, 8'd200);
        sense_expect('h20, 15, "R4 seek clamp");
        seek_cmd(8'h0F, 8'h04, 8'd8);
        sense_expect('h24, 8, "R6 head select in st0");

        // read-ID
        bus_write(3'd5, 8'h0A);
        bus_write(3'd5, 8'h04);
        begin
            int n = 0;
            do begin
                @(negedge clk); addr = 3'd4; #1;
                n++;
                if (n < DELAY) begin
                    check(int'(rdata), 'h10, "R8 busy during execution");
                    check(int'(irq), 0, "R8 no irq during execution");
                end
            end while (rdata != 8'hD0 && n < 50);
            check(n, DELAY, "R8 execution length");
        end
        #1 check(int'(irq), 1, "R8 irq at result");
        bus_write(3'd5, 8'hAA);
        pop_data('h04, "R3 write in result ignored / R8 st0");
        pop_data('h00, "R8 st1");
        pop_data('h00, "R8 st2");
        pop_data(8, "R8 cylinder");
        pop_data(1, "R8 head");
        pop_data(1, "R8 sector");
        #1 check(int'(irq), 1, "R10 irq held before last byte");
        pop_data(2, "R8 size");
        #1 check(int'(irq), 0, "R10 irq dropped after read-ID");
        expect_reg(3'd4, 'h80, "R12 idle after read-ID");

        // read
        bus_write(3'd5, 8'hE6);
        bus_write(3'd5, 8'h00);
        bus_write(3'd5, 8'd3);
        bus_write(3'd5, 8'd0);
        bus_write(3'd5, 8'd1);
        bus_write(3'd5, 8'd2);
        bus_write(3'd5, 8'd1);
        bus_write(3'd5, 8'h1B);
        #1 check(int'(irq), 0, "R10 no irq before last byte");
        bus_write(3'd5, 8'hFF);
        expect_reg(3'd4, 'hD0, "R9 immediate result");
        #1 check(int'(irq), 1, "R9 irq raised");
        pop_data('h40, "R9 st0");
        pop_data(0, "R9 st1");
        pop_data(0, "R9 st2");
        pop_data(3, "R9 cylinder");
        pop_data(0, "R9 head");
        pop_data(1, "R9 sector");
        pop_data(2, "R9 size");
        #1 check(int'(irq), 0, "R10 irq dropped after read");

        // verify
        bus_write(3'd5, 8'h16);
        bus_write(3'd5, 8'h05);
        bus_write(3'd5, 8'd7);
        bus_write(3'd5, 8'd1);
        bus_write(3'd5, 8'd4);
        bus_write(3'd5, 8'd2);
        bus_write(3'd5, 8'd4);
        bus_write(3'd5, 8'h1B);
        bus_write(3'd5, 8'hFF);
        pop_data('h45, "R9 verify st0");
        pop_data(0, "R9 verify st1");
        pop_data(0, "R9 verify st2");
        pop_data(7, "R9 verify cylinder");
        pop_data(1, "R9 verify head");
        pop_data(4, "R9 verify sector");
        pop_data(2, "R9 verify size");
        expect_reg(3'd4, 'h80, "R12 idle after verify");

        // invalid opcode
        bus_write(3'd5, 8'h1F);
        expect_reg(3'd4, 'hD0, "R11 invalid result phase");
        #1 check(int'(irq), 0, "R11 no irq");
        pop_data('h80, "R11 invalid status");
        expect_reg(3'd4, 'h80, "R11 back to idle");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule